// File: doc/BRIEF.md
# Texture Upload Sequencer

This block takes one 32-bit texture upload descriptor, latched on a start pulse, and turns it into a stream of 8x8 tile placement requests for a downstream tile writer. The descriptor gives the texture size, its corner in the texture sheet, a sheet page, a pixel depth and an upload mode. The mode chooses the full-size image, its reduced (mipmap) levels, or both. Each rectangle to be written is covered by tile requests in raster order. Every request carries the sheet coordinate of the tile and the byte offset of its pixels in the source stream.

Mipmap levels do not follow the base image. Each level goes to a fixed corner region of the sheet that depends on its level number, shifted by the base position divided by a power of two. The block moves no pixel data. It only sequences addresses, so the tile writer fetches from the source offset and stores at the sheet coordinate.

Top module: `tex_upload_seq`

## Requirements
- R1: After reset, busy, done and tile_valid are all 0.
- R2: Width is 32 << hdr[16:14] and height is 32 << hdr[19:17]. A level of width W and height H produces (W/8)*(H/8) tile requests.
- R3: The first base-level tile is at x = hdr[5:0]*32 and y = hdr[11:7]*32, plus 1024 on y when hdr[20] is 1.
- R4: Within a level, tiles go left to right and then top to bottom. The y step between rows is 8. The x step is 8 when hdr[23] is 1 (16-bit pixels) and 4 when hdr[23] is 0 (8-bit pixels, two per texel).
- R5: Mode hdr[27:24]: 0 gives the base level then mipmaps, 1 gives the base level only, 2 gives mipmaps only. Any other value leaves busy, done and tile_valid at 0.
- R6: Mip level n (n = 0 for the first reduced level) starts at x = XB[n] + xbase/2^(n+1) and y = YB[n] + yrow/2^(n+1), plus 1024 on y when the page bit is set. XB = 1024,1536,1792,1920,1984,2016,2032,2040,2044,2046,2047 and YB = 512,768,896,960,992,1008,1016,1020,1022,1023,0.
- R7: Each mip level halves both dimensions of the level before it. A further level follows only while both current dimensions exceed 8.
- R8: The source offset is 0 for the first tile of an upload, in every mode. It grows by 64 bytes per accepted tile for 8-bit pixels and by 128 for 16-bit pixels, and it keeps counting across levels.
- R9: While tile_valid is 1 and tile_ready is 0, tile_valid stays 1 and tile_x, tile_y and tile_src hold their values.
- R10: A start pulse while busy is ignored, and hdr is only sampled on an accepted start.
- R11: Done is 1 for exactly one cycle, the cycle after the last tile is accepted. Busy falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an upload using hdr |
| hdr | input | 32 | Upload descriptor |
| busy | output | 1 | Upload in progress |
| done | output | 1 | One-cycle completion pulse |
| tile_valid | output | 1 | Tile request present |
| tile_ready | input | 1 | Tile writer accepts the request |
| tile_x | output | COORD_W | Sheet x of the tile |
| tile_y | output | COORD_W | Sheet y of the tile |
| tile_src | output | SRC_W | Source byte offset of the tile |

## Verification
The assertions take for granted that the tile writer may lower tile_ready in any cycle, and that start and hdr may change freely, including while an upload runs. They also assume the descriptor keeps the sheet coordinates within COORD_W bits. The stimulus drops tile_ready on an irregular pattern in most runs and holds it high in others. It fires a second, conflicting start in the middle of every valid upload and replaces hdr right after each start. It keeps size fields small enough that every sheet coordinate fits in the coordinate width.

// File: rtl/tex_pkg.sv
package tex_pkg;

  localparam int HDR_W     = 32;
  localparam int X_LSB     = 0;
  localparam int Y_LSB     = 7;
  localparam int W_LSB     = 14;
  localparam int H_LSB     = 17;
  localparam int PAGE_BIT  = 20;
  localparam int DEPTH_BIT = 23;
  localparam int MODE_LSB  = 24;

  localparam logic [3:0] MODE_BOTH = 4'd0;
  localparam logic [3:0] MODE_BASE = 4'd1;
  localparam logic [3:0] MODE_MIPS = 4'd2;

  typedef struct packed {
    logic [5:0] xf;
    logic [4:0] yf;
    logic       page;
    logic [2:0] wlog;
    logic [2:0] hlog;
    logic       px16;
    logic [3:0] mode;
  } tex_fld_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_RUN  = 2'd2
  } seq_st_t;

endpackage

// File: rtl/tex_hdr_decode.sv
module tex_hdr_decode
  import tex_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output tex_fld_t         fld,
  output logic             mode_ok
);

  logic unused_hdr_bits;
  assign unused_hdr_bits = ^{hdr[31:28], hdr[22:21], hdr[13:12], hdr[6]};

  always_comb begin
    fld.xf   = hdr[X_LSB +: 6];
    fld.yf   = hdr[Y_LSB +: 5];
    fld.page = hdr[PAGE_BIT];
    fld.wlog = hdr[W_LSB +: 3];
    fld.hlog = hdr[H_LSB +: 3];
    fld.px16 = hdr[DEPTH_BIT];
    fld.mode = hdr[MODE_LSB +: 4];
  end

  assign mode_ok = (fld.mode == MODE_BOTH) || (fld.mode == MODE_BASE) ||
                   (fld.mode == MODE_MIPS);

endmodule

// File: rtl/tex_level_geom.sv
module tex_level_geom
  import tex_pkg::*;
#(
  parameter int COORD_W = 13,
  parameter int CNT_W   = 10,
  parameter int LVL_W   = 4
) (
  input  tex_fld_t           fld,
  input  logic [LVL_W-1:0]   lvl,
  output logic [COORD_W-1:0] rx,
  output logic [COORD_W-1:0] ry,
  output logic [CNT_W-1:0]   cols,
  output logic [CNT_W-1:0]   rows,
  output logic               more
);

  localparam logic [COORD_W-1:0] SHEET_W  = COORD_W'(2048);
  localparam logic [COORD_W-1:0] HALF_W   = COORD_W'(1024);
  localparam logic [COORD_W-1:0] ROW_SPAN = COORD_W'(1024);
  localparam logic [COORD_W-1:0] HALF_R   = COORD_W'(512);
  localparam logic [CNT_W-1:0]   TILES32  = CNT_W'(4);
  localparam logic [CNT_W-1:0]   ONE      = CNT_W'(1);

  logic [COORD_W-1:0] xpix, ypix, pgoff, xcorner, ycorner;
  logic [LVL_W-1:0]   mip_n;

  assign xpix  = COORD_W'(fld.xf) << 5;
  assign ypix  = COORD_W'(fld.yf) << 5;
  assign pgoff = fld.page ? ROW_SPAN : '0;
  assign mip_n = lvl - LVL_W'(1);

  assign xcorner = SHEET_W - (HALF_W >> mip_n);
  assign ycorner = (mip_n == LVL_W'(10)) ? '0 : (ROW_SPAN - (HALF_R >> mip_n));

  always_comb begin
    if (lvl == '0) begin
      rx = xpix;
      ry = ypix + pgoff;
    end else begin
      rx = xcorner + (xpix >> lvl);
      ry = ycorner + (ypix >> lvl) + pgoff;
    end
  end

  assign cols = (TILES32 << fld.wlog) >> lvl;
  assign rows = (TILES32 << fld.hlog) >> lvl;
  assign more = (cols > ONE) && (rows > ONE);

endmodule

// File: rtl/tex_tile_walker.sv
module tex_tile_walker #(
  parameter int COORD_W = 13,
  parameter int CNT_W   = 10,
  parameter int SRC_W   = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               clear_src,
  input  logic [COORD_W-1:0] rx,
  input  logic [COORD_W-1:0] ry,
  input  logic [CNT_W-1:0]   cols,
  input  logic [CNT_W-1:0]   rows,
  input  logic               px16,
  input  logic               tile_ready,
  output logic               tile_valid,
  output logic [COORD_W-1:0] tile_x,
  output logic [COORD_W-1:0] tile_y,
  output logic [SRC_W-1:0]   tile_src,
  output logic               fin
);

  localparam logic [CNT_W-1:0]   ONE   = CNT_W'(1);
  localparam logic [COORD_W-1:0] ROW_H = COORD_W'(8);

  logic [CNT_W-1:0]   col_q, row_q, cols_q, rows_q;
  logic [COORD_W-1:0] left_q;
  logic               take, end_col, end_row;

  assign take    = tile_valid && tile_ready;
  assign end_col = (col_q == cols_q - ONE);
  assign end_row = (row_q == rows_q - ONE);
  assign fin     = take && end_col && end_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      tile_valid <= 1'b0;
      col_q      <= '0;
      row_q      <= '0;
      cols_q     <= ONE;
      rows_q     <= ONE;
      left_q     <= '0;
      tile_x     <= '0;
      tile_y     <= '0;
      tile_src   <= '0;
    end else begin
      if (clear_src)
        tile_src <= '0;
      else if (take)
        tile_src <= tile_src + (px16 ? SRC_W'(128) : SRC_W'(64));

      if (load) begin
        tile_valid <= 1'b1;
        col_q      <= '0;
        row_q      <= '0;
        cols_q     <= cols;
        rows_q     <= rows;
        left_q     <= rx;
        tile_x     <= rx;
        tile_y     <= ry;
      end else if (take) begin
        if (end_col && end_row) begin
          tile_valid <= 1'b0;
        end else if (end_col) begin
          col_q  <= '0;
          row_q  <= row_q + ONE;
          tile_x <= left_q;
          tile_y <= tile_y + ROW_H;
        end else begin
          col_q  <= col_q + ONE;
          tile_x <= tile_x + (px16 ? COORD_W'(8) : COORD_W'(4));
        end
      end
    end
  end

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    tile_valid |-> (col_q < cols_q) && (row_q < rows_q)); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tile_valid && !tile_ready) |=>
      tile_valid && $stable(tile_x) && $stable(tile_y) && $stable(tile_src)); // R9

endmodule

// File: rtl/tex_upload_seq.sv
module tex_upload_seq
  import tex_pkg::*;
#(
  parameter int COORD_W = 13,
  parameter int CNT_W   = 10,
  parameter int SRC_W   = 26,
  parameter int LVL_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [31:0]        hdr,
  output logic               busy,
  output logic               done,
  output logic               tile_valid,
  input  logic               tile_ready,
  output logic [COORD_W-1:0] tile_x,
  output logic [COORD_W-1:0] tile_y,
  output logic [SRC_W-1:0]   tile_src
);

  seq_st_t            state_q;
  tex_fld_t           fld_in, fld_q;
  logic               mode_ok;
  logic [LVL_W-1:0]   lvl_q;
  logic [COORD_W-1:0] rx, ry;
  logic [CNT_W-1:0]   cols, rows;
  logic               more, fin, accept;

  tex_hdr_decode u_dec (
    .hdr     (hdr),
    .fld     (fld_in),
    .mode_ok (mode_ok)
  );

  tex_level_geom #(.COORD_W(COORD_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_geom (
    .fld  (fld_q),
    .lvl  (lvl_q),
    .rx   (rx),
    .ry   (ry),
    .cols (cols),
    .rows (rows),
    .more (more)
  );

  assign accept = (state_q == SQ_IDLE) && start && mode_ok;

  tex_tile_walker #(.COORD_W(COORD_W), .CNT_W(CNT_W), .SRC_W(SRC_W)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .load       (state_q == SQ_LOAD),
    .clear_src  (accept),
    .rx         (rx),
    .ry         (ry),
    .cols       (cols),
    .rows       (rows),
    .px16       (fld_q.px16),
    .tile_ready (tile_ready),
    .tile_valid (tile_valid),
    .tile_x     (tile_x),
    .tile_y     (tile_y),
    .tile_src   (tile_src),
    .fin        (fin)
  );

  assign busy = (state_q != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      fld_q   <= '0;
      lvl_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        SQ_IDLE: if (accept) begin
          fld_q   <= fld_in;
          lvl_q   <= (fld_in.mode == MODE_MIPS) ? LVL_W'(1) : '0;
          state_q <= SQ_LOAD;
        end
        SQ_LOAD: state_q <= SQ_RUN;
        SQ_RUN: if (fin) begin
          if ((fld_q.mode != MODE_BASE) && more) begin
            lvl_q   <= lvl_q + LVL_W'(1);
            state_q <= SQ_LOAD;
          end else begin
            state_q <= SQ_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tile_valid); // R5

  AST_BAD_MODE: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (hdr[MODE_LSB +: 4] > 4'd2)) |=> !busy); // R5

  AST_SRC_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (tile_src == '0)); // R8

  AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lvl_q <= LVL_W'(9))); // R7

endmodule

// File: tb/sim_tex_upload_seq.sv
`timescale 1ns/1ps
module sim_tex_upload_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] hdr = '0;
  logic        tile_ready = 1'b0;
  logic        busy, done, tile_valid;
  logic [12:0] tile_x, tile_y;
  logic [25:0] tile_src;

  int n_chk = 0;
  int n_fail = 0;
  int rp = 0;
  int xb_tab[11] = '{1024, 1536, 1792, 1920, 1984, 2016, 2032, 2040, 2044, 2046, 2047};
  int yb_tab[11] = '{512, 768, 896, 960, 992, 1008, 1016, 1020, 1022, 1023, 0};

  always #2 clk = ~clk;

  tex_upload_seq u0 (
    .clk(clk), .rst(rst), .start(start), .hdr(hdr), .busy(busy), .done(done),
    .tile_valid(tile_valid), .tile_ready(tile_ready),
    .tile_x(tile_x), .tile_y(tile_y), .tile_src(tile_src)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(int wl, int hl, int b16, int mode, int pg, int xf, int yf);
    return (32'(mode) << 24) | (32'(b16) << 23) | (32'(pg) << 20) |
           (32'(hl) << 17) | (32'(wl) << 14) | (32'(yf) << 7) | 32'(xf);
  endfunction

  task automatic run_bad(input int wl, input int hl, input int mode);
    @(negedge clk);
    start = 1'b1; hdr = mk_hdr(wl, hl, 1, mode, 0, 3, 2);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R5 bad mode busy", busy, 0);
      chk("R5 bad mode tile_valid", tile_valid, 0);
      chk("R5 bad mode done", done, 0);
      @(negedge clk);
    end
  endtask

  task automatic run_ok(input int wl, input int hl, input int b16, input int mode,
                        input int pg, input int xf, input int yf, input int always_rdy);
    int w, h, lv, src, k, guard, px, py, ps, step;
    bit go, injected, hold;
    w = 32 << wl; h = 32 << hl;
    lv = (mode == 2) ? 1 : 0;
    src = 0; k = 0; go = 1; injected = 0; hold = 0;
    step = b16 ? 8 : 4;
    @(negedge clk);
    start = 1'b1; hdr = mk_hdr(wl, hl, b16, mode, pg, xf, yf);
    @(negedge clk);
    start = 1'b0; hdr = mk_hdr(0, 0, 1, 1, 1, 60, 30);
    chk("R10 busy after accepted start", busy, 1);
    while (go) begin
      int wl_px, hl_px, x0, y0;
      wl_px = w >> lv; hl_px = h >> lv;
      if (lv == 0) begin
        x0 = xf * 32; y0 = yf * 32 + pg * 1024;
      end else begin
        x0 = xb_tab[lv-1] + ((xf * 32) >> lv);
        y0 = yb_tab[lv-1] + ((yf * 32) >> lv) + pg * 1024;
      end
      for (int r = 0; r < hl_px / 8; r++) begin
        for (int c = 0; c < wl_px / 8; c++) begin
          guard = 0;
          do begin
            @(negedge clk);
            rp++;
            tile_ready = always_rdy ? 1'b1 : (((rp * 3 + xf) % 7) < 5);
            if (k == 1 && !injected) begin
              start = 1'b1; injected = 1;
            end else begin
              start = 1'b0;
            end
            if (hold) begin
              chk("R9 valid held", tile_valid, 1);
              chk("R9 x held", tile_x, px);
              chk("R9 y held", tile_y, py);
              chk("R9 src held", tile_src, ps);
            end
            hold = tile_valid && !tile_ready;
            px = tile_x; py = tile_y; ps = tile_src;
            guard++;
            if (guard > 4000) begin
              chk("R11 tile request timeout", 0, 1);
              start = 1'b0;
              return;
            end
          end while (!(tile_valid && tile_ready));
          if (lv == 0 && r == 0 && c == 0) begin
            chk("R3 base x", tile_x, x0);
            chk("R3 base y", tile_y, y0);
          end else if (lv == 0) begin
            chk("R4 raster x", tile_x, x0 + c * step);
            chk("R4 raster y", tile_y, y0 + r * 8);
          end else begin
            chk("R6 mip x", tile_x, x0 + c * step);
            chk("R6 mip y", tile_y, y0 + r * 8);
          end
          chk("R8 source offset", tile_src, src);
          chk("R11 done low before end", done, 0);
          src += b16 ? 128 : 64;
          k++;
        end
      end
      if (mode != 1 && wl_px > 8 && hl_px > 8) lv++;
      else go = 0;
    end
    @(negedge clk);
    start = 1'b0;
    tile_ready = 1'b0;
    chk("R2/R7 R11 done after expected tile count", done, 1);
    chk("R11 busy falls with done", busy, 0);
    @(negedge clk);
    chk("R11 done lasts one cycle", done, 0);
    chk("R10 late start left no upload", tile_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 tile_valid after reset", tile_valid, 0);
    for (int wl = 0; wl < 3; wl++)
      for (int hl = 0; hl < 3; hl++)
        for (int b = 0; b < 2; b++)
          for (int m = 0; m < 3; m++)
            for (int pg = 0; pg < 2; pg++) begin
              run_ok(wl, hl, b, m, pg, (idx * 13 + 5) % 64, (idx * 7 + 3) % 32, idx % 4 == 0);
              idx++;
            end
    run_ok(3, 1, 0, 0, 1, 17, 29, 0);
    run_ok(0, 4, 1, 2, 0, 63, 31, 1);
    run_ok(4, 0, 1, 0, 0, 40, 9, 0);
    run_bad(1, 1, 3);
    run_bad(0, 2, 7);
    run_bad(2, 0, 15);
    run_ok(0, 0, 1, 1, 0, 0, 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule